// File: doc/BRIEF.md
# First-Order Sigma-Delta Audio DAC

This block turns a 15-bit unsigned audio level into a one-bit pulse-density stream on a single output pin, which drives an external RC low-pass filter. The level is the sum of two 14-bit channel values presented on the input. Each channel value is the product of an 8-bit sample and a 6-bit volume, and that product is formed upstream. The block latches this sum when a valid strobe arrives. The modulator then advances one step on each cycle where the step enable is high, so the system clock can run faster than the modulation rate. Stepping every fourth cycle of a 28 MHz clock gives about 7 MHz, and stepping every cycle gives the full rate.

On each step, the latched level is added into an error accumulator of the same width. The carry out of that addition becomes the next output bit. At very small input levels a first-order loop produces pulses that are spaced widely and evenly. The slowest pattern can repeat only once every 32768 steps, which at about 7 MHz is an audible tone near 216 Hz. To break this up, a programmable timer can zero the accumulator every P steps. A shorter P discards more of the fine residue. A period of zero turns the clearing off.

Top module: `sddac_pdm`

## Requirements
- R1: While reset is asserted, the output is 0, and the accumulator, the clear timer and the latched level are all zero.
- R2: The level is loaded as ch_a + ch_b, with no overflow, only in cycles where smp_valid is high. In all other cycles it holds, whatever happens on the channel inputs.
- R3: On a clock edge where step_en is high and no clear is due, the accumulator becomes the low 15 bits of accumulator + level. pdm_out takes the carry of that sum and is valid right after the edge.
- R4: On an edge where step_en is low, pdm_out, the accumulator and the clear timer do not change.
- R5: Starting from a zero accumulator, with a constant level N and no clearing, pdm_out is high on exactly N of 32768 consecutive steps. After step k it has been high floor(k·N/32768) times.
- R6: When clr_period = P is nonzero, every P-th step after reset zeroes the accumulator and forces pdm_out to 0. The count restarts after each clear.
- R7: When clr_period is 0, no clear ever happens.
- R8: Loading a new level does not disturb the accumulator. The residue carries into the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Modulator step enable |
| smp_valid | input | 1 | Load strobe for the channel sum |
| ch_a | input | 14 | First channel value |
| ch_b | input | 14 | Second channel value |
| clr_period | input | 16 | Steps between accumulator clears; 0 disables clearing |
| pdm_out | output | 1 | Pulse-density output bit |

## Verification
The bench runs full 32768-step windows at a level of 1, a mid level and the largest possible level. At every step it compares the running count of high outputs with floor(k·N/32768). A design that drops the carry or saturates the accumulator goes wrong at once at the extremes. With a clear period of 5, the bench expects the pattern to restart every fifth step. A timer that is off by one shifts that restart. The bench also checks that changing the level keeps the residue, that channel changes without the strobe are ignored, and that idle cycles freeze the output. A design that clears on every reload, follows the inputs directly, or steps on every clock breaks one of these checks.

// File: rtl/sddac_pdm.sv
module sddac_pdm #(
  parameter int CH_W  = 14,
  parameter int TMR_W = 16,
  localparam int IN_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             smp_valid,
  input  logic [CH_W-1:0]  ch_a,
  input  logic [CH_W-1:0]  ch_b,
  input  logic [TMR_W-1:0] clr_period,
  output logic             pdm_out
);

  logic [IN_W-1:0]  smp;
  logic [IN_W-1:0]  acc;
  logic [TMR_W-1:0] tmr;
  logic [IN_W:0]    sum;
  logic             clr_due;

  assign sum     = {1'b0, acc} + {1'b0, smp};
  assign clr_due = (clr_period != '0) && (tmr >= clr_period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      smp <= '0;
    else if (smp_valid)
      smp <= {1'b0, ch_a} + {1'b0, ch_b};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      tmr     <= '0;
      pdm_out <= 1'b0;
    end else if (step_en) begin
      if (clr_due) begin
        acc     <= '0;
        tmr     <= '0;
        pdm_out <= 1'b0;
      end else begin
        acc     <= sum[IN_W-1:0];
        pdm_out <= sum[IN_W];
        tmr     <= (clr_period == '0) ? '0 : tmr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sddac_pdm_chk.sv
module sddac_pdm_chk #(
  parameter int IN_W  = 15,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             smp_valid,
  input logic [TMR_W-1:0] clr_period,
  input logic [IN_W-1:0]  smp,
  input logic [IN_W-1:0]  acc,
  input logic [TMR_W-1:0] tmr,
  input logic             pdm_out
);

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pdm_out && acc == '0 && tmr == '0));

  // R2
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(smp));

  // R3
  carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !(clr_period != '0 && tmr >= clr_period - 1'b1))
    |=> (pdm_out == ((({1'b0, $past(acc)} + {1'b0, $past(smp)}) >> IN_W) != 0)));

  // R4
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(pdm_out) && $stable(acc) && $stable(tmr)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && clr_period != '0 && tmr >= clr_period - 1'b1) |=> (!pdm_out && acc == '0));

  // R7
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && clr_period == '0) |=> (tmr == '0));

endmodule

bind sddac_pdm sddac_pdm_chk #(.IN_W(IN_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .smp_valid(smp_valid),
  .clr_period(clr_period), .smp(smp), .acc(acc), .tmr(tmr), .pdm_out(pdm_out)
);

// File: tb/sddac_pdm_tb.sv
module sddac_pdm_tb;
  localparam int CLK_NS = 10;
  localparam int STEPS  = 32768;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        step_en = 0;
  logic        smp_valid = 0;
  logic [13:0] ch_a = 0;
  logic [13:0] ch_b = 0;
  logic [15:0] clr_period = 0;
  logic        pdm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sddac_pdm u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; step_en = 0; smp_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic load(input int a, input int b);
    @(negedge clk); ch_a = 14'(a); ch_b = 14'(b); smp_valid = 1;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic step1(output logic o);
    @(negedge clk); step_en = 1;
    @(negedge clk); step_en = 0; o = pdm_out;
  endtask

  task automatic density(input int a, input int b, input string req);
    longint n = a + b;
    longint ones = 0;
    int bad = 0;
    do_reset();
    clr_period = 0;
    load(a, b);
    @(negedge clk); step_en = 1;
    for (int k = 1; k <= STEPS; k++) begin
      @(negedge clk);
      ones += pdm_out;
      if (ones != (longint'(k) * n) / STEPS) bad++;
    end
    step_en = 0;
    chk({req, " per-step count"}, bad, 0);
    chk({req, " total ones"}, ones, n);
  endtask

  initial begin
    logic o;
    int bad;
    longint lv;
    @(negedge clk);
    // R1: output low during reset
    chk("R1 out in reset", pdm_out, 0);
    do_reset();
    chk("R1 out after reset", pdm_out, 0);

    // R5, R7 density windows with clearing off
    density(1, 0, "R5 R7 N=1");
    density(10000, 10000, "R5 N=20000");
    density(16383, 16383, "R5 N=32766");

    // R6: clear every 5 steps, level 20000
    do_reset();
    clr_period = 5;
    load(10000, 10000);
    bad = 0;
    lv = 20000;
    @(negedge clk); step_en = 1;
    for (int k = 1; k <= 60; k++) begin
      int j;
      longint e;
      @(negedge clk);
      j = k % 5;
      e = (j == 0) ? 0 : ((j * lv) / STEPS) - (((j - 1) * lv) / STEPS);
      if (pdm_out != e[0]) bad++;
    end
    step_en = 0;
    chk("R6 clear pattern P=5", bad, 0);
    // R6: a large level that would carry on the clear step
    do_reset();
    clr_period = 2;
    load(16383, 16383);
    step1(o); chk("R6 step1 P=2", o, 0);
    step1(o); chk("R6 clear step forces 0", o, 0);
    step1(o); chk("R6 after clear", o, 0);
    step1(o); chk("R6 clear again", o, 0);
    clr_period = 0;
    step1(o); chk("R7 period 0 runs free", o, 0);
    step1(o); chk("R7 carry appears", o, 1);

    // R8: residue kept across a reload
    do_reset();
    load(8192, 8192);
    step1(o); chk("R8 first half", o, 0);
    load(8192, 8192);
    step1(o); chk("R8 residue carried", o, 1);

    // R2: channel change without strobe is ignored
    do_reset();
    load(8192, 8192);
    @(negedge clk); ch_a = 0; ch_b = 0;
    step1(o); chk("R2 held level step1", o, 0);
    step1(o); chk("R2 held level step2", o, 1);

    // R3, R4: carry timing and idle hold
    do_reset();
    load(16383, 16384 - 1);
    step1(o); chk("R3 first step", o, 0);
    step1(o); chk("R3 carry step", o, 1);
    @(negedge clk); ch_a = 0; smp_valid = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smp_valid = 0;
      chk("R4 idle hold", pdm_out, 1);
    end
    // acc=32764, level now 16383: sum 49147 -> carry 1
    step1(o); chk("R4 acc held then R3", o, 1);
    step1(o); chk("R3 no carry", o, 0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule